// File: doc/BRIEF.md
# Block Protection and Status Controller

This controller sits beside the serial front end of a small nonvolatile byte memory. It holds the write-enable latch and the three protection settings, and it assembles the 8-bit status byte that a status read returns. The protocol decoder gives it single-cycle strobes: enable writes, disable writes, write the status register (with a data byte), start a write cycle and end a write cycle. It also receives the level of the chip select, the active-low write-protect pin, a busy flag from the write timer and an array address to test. From these it reports whether the latch is set, whether an array write to the queried address may go ahead, and whether a status-register write would be accepted now.

The protection settings are a lock bit and a two-bit block level. The level selects no protection, the top quarter, the top half or the whole array. The lock bit lets the write-protect pin freeze the status register. The settings only change when a status write cycle completes. They model nonvolatile cells: a soft reset leaves them alone, and they are zero at time zero.

A sequencer with four states carries a status write from request to commit. ST_IDLE goes to ST_SR_ARMED on an accepted status-write strobe (the arm transition), and to ST_ARR_PROG on a start strobe while the latch is set (the array-start transition). ST_SR_ARMED goes to ST_SR_PROG on the start strobe (the sr-start transition). It goes back to ST_IDLE when the pin falls while chip select is low and the lock bit is set (the abort transition). ST_SR_PROG and ST_ARR_PROG return to ST_IDLE on the end strobe (the sr-done and array-done transitions); sr-done commits the captured settings.

Top module: `wprot_status_ctrl`

## Requirements
- R1: Outside a write cycle the status byte is {lock, 3'b000, level[1], level[0], latch, 1'b0}. Bit 7 is the lock bit, bits 3:2 the block level and bit 1 the latch. The reserved bits 6:4 always read 0 there, even if a status write supplied ones in them.
- R2: While the sequencer is in ST_SR_PROG or ST_ARR_PROG, or while `busy_i` is high, the status byte reads 8'hFF.
- R3: After reset the latch is 0. The enable strobe sets it. The disable strobe clears it whatever the level of `wp_n_i`, and the disable strobe wins if both arrive together.
- R4: The latch clears on the end strobe of any status or array write cycle.
- R5: During a write cycle the enable, disable and status-write strobes are ignored.
- R6: `addr_ok_o` is 1 only when the latch is set and the queried address lies outside the protected range. Level 00 protects nothing, 01 protects addresses at or above 3/4 of DEPTH, 10 those at or above DEPTH/2, and 11 all addresses.
- R7: When `wp_n_i` is 0 and the lock bit is 1, status writes are refused: `sr_wr_ok_o` is 0 and a status-write strobe leaves the sequencer in ST_IDLE.
- R8: When the lock bit is 0, `wp_n_i` has no effect: with the pin low, a status write still takes effect.
- R9: In ST_SR_ARMED, the pin going low while `cs_n_i` is 0 and the lock bit is 1 aborts the pending status write. Once ST_SR_PROG is entered, the pin has no effect on the commit.
- R10: A status write needs the latch and a `sr_wr_ok_o` of 1 when strobed. Data bits 7, 3 and 2 become the lock bit and the level when the cycle ends. The sequencer holds the request in ST_SR_ARMED, during which `sr_wr_ok_o` reads 0.
- R11: A soft reset leaves the lock bit and the level unchanged. Both are 0 at time zero.
- R12: A start strobe in ST_IDLE with the latch clear starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low soft reset (sequencer and latch only) |
| set_en_i | input | 1 | Enable-writes strobe |
| clr_en_i | input | 1 | Disable-writes strobe |
| sr_wr_i | input | 1 | Status-write strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| cs_n_i | input | 1 | Chip select level, active low |
| wp_n_i | input | 1 | Write-protect pin, active low |
| cyc_start_i | input | 1 | Write-cycle start strobe |
| cyc_done_i | input | 1 | Write-cycle end strobe |
| busy_i | input | 1 | Write timer busy flag |
| query_addr_i | input | ADDR_W | Array address to test |
| status_o | output | 8 | Status byte |
| wel_o | output | 1 | Write-enable latch |
| addr_ok_o | output | 1 | Array write to query address allowed |
| sr_wr_ok_o | output | 1 | Status write would be accepted |

## Verification
The bench builds the controller with DEPTH set to 64, so the quarter boundary falls at address 48 and the half boundary at 32. This puts the last allowed and first protected addresses of each level, as well as the top address, within a few directed queries. With the small depth, every level, the pin and lock combinations, the abort window and the commit after the pin falls can each be reached in a short sequence of strobes.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SR_ARMED = 2'd1,
        ST_SR_PROG  = 2'd2,
        ST_ARR_PROG = 2'd3
    } wp_state_e;

    localparam int STAT_W   = 8;
    localparam int LOCK_POS = 7;
    localparam int LVL_HI   = 3;
    localparam int LVL_LO   = 2;

    typedef struct packed {
        logic       lock;
        logic [1:0] level;
    } nv_bits_t;

endpackage

// File: rtl/wprot_range.sv
module wprot_range #(
    parameter int DEPTH  = 8192,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        level_i,
    output logic              prot_o
);
    localparam int QUART_START = DEPTH - DEPTH / 4;
    localparam int HALF_START  = DEPTH / 2;
    localparam logic [ADDR_W-1:0] QUART_A = ADDR_W'(QUART_START);
    localparam logic [ADDR_W-1:0] HALF_A  = ADDR_W'(HALF_START);

    always_comb begin
        unique case (level_i)
            2'b00:   prot_o = 1'b0;
            2'b01:   prot_o = (addr_i >= QUART_A);
            2'b10:   prot_o = (addr_i >= HALF_A);
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wprot_nv_bits.sv
module wprot_nv_bits
    import wprot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit_i,
    input  nv_bits_t commit_bits_i,
    output nv_bits_t bits_o
);
    nv_bits_t bits_q = '0;

    always_ff @(posedge clk) begin
        if (commit_i) begin
            bits_q <= commit_bits_i;
        end
    end

    assign bits_o = bits_q;

    // R11
    nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(bits_q));
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
    import wprot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_en_i,
    input  logic       clr_en_i,
    input  logic       sr_wr_i,
    input  logic [7:0] sr_data_i,
    input  logic       cs_n_i,
    input  logic       wp_n_i,
    input  logic       cyc_start_i,
    input  logic       cyc_done_i,
    input  logic       busy_i,
    input  logic       lock_i,
    output logic       wel_o,
    output logic       in_cyc_o,
    output logic       sr_wr_ok_o,
    output logic       commit_o,
    output nv_bits_t   commit_bits_o
);
    wp_state_e state_q, state_d;
    logic      wel_q;
    nv_bits_t  pend_q;
    logic      hw_lock;
    logic      in_prog;
    logic      arm_ok;

    assign hw_lock = !wp_n_i && lock_i;
    assign in_prog = (state_q == ST_SR_PROG) || (state_q == ST_ARR_PROG);
    assign arm_ok  = (state_q == ST_IDLE) && wel_q && !hw_lock && !busy_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!busy_i && cyc_start_i && wel_q) begin
                    state_d = ST_ARR_PROG;
                end else if (sr_wr_i && arm_ok) begin
                    state_d = ST_SR_ARMED;
                end
            end
            ST_SR_ARMED: begin
                if (hw_lock && !cs_n_i) begin
                    state_d = ST_IDLE;
                end else if (cyc_start_i) begin
                    state_d = ST_SR_PROG;
                end
            end
            ST_SR_PROG: begin
                if (cyc_done_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ARR_PROG: begin
                if (cyc_done_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            if (in_prog && cyc_done_i) begin
                wel_q <= 1'b0;
            end else if (!in_prog && !busy_i) begin
                if (clr_en_i) begin
                    wel_q <= 1'b0;
                end else if (set_en_i) begin
                    wel_q <= 1'b1;
                end
            end
            if (state_q == ST_IDLE && sr_wr_i && arm_ok && !cyc_start_i) begin
                pend_q.lock  <= sr_data_i[LOCK_POS];
                pend_q.level <= sr_data_i[LVL_HI:LVL_LO];
            end
        end
    end

    always_comb begin
        wel_o         = wel_q;
        in_cyc_o      = in_prog || busy_i;
        sr_wr_ok_o    = arm_ok;
        commit_o      = (state_q == ST_SR_PROG) && cyc_done_i;
        commit_bits_o = pend_q;
    end

    // R4
    wel_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && cyc_done_i) |=> !wel_q);

    // R5
    ignore_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_prog || busy_i) && !cyc_done_i) |=> $stable(wel_q));

    // R7
    hwp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && sr_wr_i && !wp_n_i && lock_i) |=> state_q != ST_SR_ARMED);

    // R9
    wp_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SR_ARMED && !wp_n_i && lock_i && !cs_n_i) |=> state_q == ST_IDLE);

    // R12
    nowel_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cyc_start_i && !wel_q) |=> state_q != ST_ARR_PROG);
endmodule

// File: rtl/wprot_status_ctrl.sv
module wprot_status_ctrl
    import wprot_pkg::*;
#(
    parameter int DEPTH  = 8192,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_data_i,
    input  logic              cs_n_i,
    input  logic              wp_n_i,
    input  logic              cyc_start_i,
    input  logic              cyc_done_i,
    input  logic              busy_i,
    input  logic [ADDR_W-1:0] query_addr_i,
    output logic [7:0]        status_o,
    output logic              wel_o,
    output logic              addr_ok_o,
    output logic              sr_wr_ok_o
);
    nv_bits_t nv_bits;
    nv_bits_t commit_bits;
    logic     commit;
    logic     in_cyc;
    logic     wel;
    logic     prot;

    wprot_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_en_i      (set_en_i),
        .clr_en_i      (clr_en_i),
        .sr_wr_i       (sr_wr_i),
        .sr_data_i     (sr_data_i),
        .cs_n_i        (cs_n_i),
        .wp_n_i        (wp_n_i),
        .cyc_start_i   (cyc_start_i),
        .cyc_done_i    (cyc_done_i),
        .busy_i        (busy_i),
        .lock_i        (nv_bits.lock),
        .wel_o         (wel),
        .in_cyc_o      (in_cyc),
        .sr_wr_ok_o    (sr_wr_ok_o),
        .commit_o      (commit),
        .commit_bits_o (commit_bits)
    );

    wprot_nv_bits u_nv (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit),
        .commit_bits_i (commit_bits),
        .bits_o        (nv_bits)
    );

    wprot_range #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_range (
        .addr_i  (query_addr_i),
        .level_i (nv_bits.level),
        .prot_o  (prot)
    );

    always_comb begin
        if (in_cyc) begin
            status_o = 8'hFF;
        end else begin
            status_o = {nv_bits.lock, 3'b000, nv_bits.level, wel, 1'b0};
        end
        wel_o     = wel;
        addr_ok_o = wel && !prot;
    end

    // R2
    busy_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> status_o == 8'hFF);

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[0] |-> status_o[6:4] == 3'b000);

    // R6
    full_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[3:2] == 2'b11 && !status_o[0]) |-> !addr_ok_o);

    // R10
    commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(nv_bits) |-> $past(commit));
endmodule

// File: tb/sim_wprot_status_ctrl.sv
module sim_wprot_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int ADDR_W     = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              set_en = 1'b0, clr_en = 1'b0, sr_wr = 1'b0;
    logic [7:0]        sr_data = 8'h00;
    logic              cs_n = 1'b1, wp_n = 1'b1;
    logic              cyc_start = 1'b0, cyc_done = 1'b0, busy = 1'b0;
    logic [ADDR_W-1:0] qaddr = '0;
    logic [7:0]        status;
    logic              wel, addr_ok, sr_ok;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        int    kind;
        int    exp;
        string tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    wprot_status_ctrl #(.DEPTH(DEPTH)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_en_i     (set_en),
        .clr_en_i     (clr_en),
        .sr_wr_i      (sr_wr),
        .sr_data_i    (sr_data),
        .cs_n_i       (cs_n),
        .wp_n_i       (wp_n),
        .cyc_start_i  (cyc_start),
        .cyc_done_i   (cyc_done),
        .busy_i       (busy),
        .query_addr_i (qaddr),
        .status_o     (status),
        .wel_o        (wel),
        .addr_ok_o    (addr_ok),
        .sr_wr_ok_o   (sr_ok)
    );

    // monitor: compares queued expectations at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                int act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = int'(status);
                    1:       act = int'(wel);
                    2:       act = int'(addr_ok);
                    default: act = int'(sr_ok);
                endcase
                checks++;
                if (act != it.exp) begin
                    failures++;
                    $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h",
                             it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int k, input int e, input string t);
        item_t it;
        it.kind = k;
        it.exp  = e;
        it.tag  = t;
        sb_q.push_back(it);
    endtask

    task automatic exp_st(input int e, input string t);   push(0, e, t); endtask
    task automatic exp_wel(input int e, input string t);  push(1, e, t); endtask
    task automatic exp_aok(input int e, input string t);  push(2, e, t); endtask
    task automatic exp_srok(input int e, input string t); push(3, e, t); endtask

    task automatic step();
        @(negedge clk);
        #1;
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_en();
        @(negedge clk); #1; set_en = 1'b1;
        @(posedge clk); #1; set_en = 1'b0;
    endtask

    task automatic pulse_dis();
        @(negedge clk); #1; clr_en = 1'b1;
        @(posedge clk); #1; clr_en = 1'b0;
    endtask

    task automatic pulse_arm(input logic [7:0] d);
        @(negedge clk); #1; cs_n = 1'b0; sr_wr = 1'b1; sr_data = d;
        @(posedge clk); #1; sr_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); #1; cs_n = 1'b1; cyc_start = 1'b1;
        @(posedge clk); #1; cyc_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); #1; cyc_done = 1'b1;
        @(posedge clk); #1; cyc_done = 1'b0;
    endtask

    task automatic set_query(input int a);
        @(negedge clk); #1; qaddr = ADDR_W'(a);
        @(posedge clk); #1;
    endtask

    task automatic set_wp(input logic v);
        @(negedge clk); #1; wp_n = v;
        @(posedge clk); #1;
    endtask

    task automatic sr_write(input logic [7:0] d, input int after, input string t);
        pulse_arm(d);
        exp_srok(0, t);
        pulse_start();
        exp_st(8'hFF, "R2 status during status write");
        pulse_done();
        exp_st(after, t);
        exp_wel(0, "R4 latch cleared at cycle end");
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        exp_st(8'h00, "R11 protection bits zero at time zero");
        exp_wel(0, "R3 latch clear in reset");
        @(negedge clk); #1; rst_n = 1'b1;
        @(posedge clk); #1;
        exp_st(8'h00, "R1 idle status after reset");
        exp_aok(0, "R6 no latch, no address allowed");

        pulse_en();
        exp_st(8'h02, "R3 enable sets latch");
        exp_aok(1, "R6 level 00 allows address 0");

        set_wp(1'b0);
        pulse_dis();
        exp_wel(0, "R3 disable with pin low");
        set_wp(1'b1);

        // R5: strobes ignored while timer busy
        @(negedge clk); #1; busy = 1'b1;
        pulse_en();
        exp_st(8'hFF, "R2 busy forces all ones");
        @(negedge clk); #1; busy = 1'b0;
        @(posedge clk); #1;
        exp_wel(0, "R5 enable ignored during cycle");

        // level 01
        pulse_en();
        sr_write(8'h04, 8'h04, "R10 commit level 01");
        pulse_en();
        set_query(47); exp_aok(1, "R6 level 01 addr 47 allowed");
        set_query(48); exp_aok(0, "R6 level 01 addr 48 protected");
        set_query(63); exp_aok(0, "R6 level 01 top address protected");

        // level 10
        sr_write(8'h08, 8'h08, "R10 commit level 10");
        pulse_en();
        set_query(31); exp_aok(1, "R6 level 10 addr 31 allowed");
        set_query(32); exp_aok(0, "R6 level 10 addr 32 protected");

        // level 11
        sr_write(8'h0C, 8'h0C, "R10 commit level 11");
        pulse_en();
        set_query(0); exp_aok(0, "R6 level 11 addr 0 protected");

        // reserved bits dropped, lock set
        sr_write(8'hF0, 8'h80, "R1 reserved bits dropped on commit");

        // R7: lock with pin low blocks status write
        pulse_en();
        set_wp(1'b0);
        exp_srok(0, "R7 status write refused");
        pulse_arm(8'h0C);
        @(negedge clk); #1; cs_n = 1'b1;
        @(posedge clk); #1;
        set_wp(1'b1);
        exp_srok(1, "R7 refused strobe left sequencer idle");
        exp_st(8'h82, "R7 settings unchanged");

        // R9: abort while armed
        pulse_arm(8'h0C);
        exp_srok(0, "R10 armed request");
        set_wp(1'b0);
        @(negedge clk); #1; cs_n = 1'b1; wp_n = 1'b1;
        @(posedge clk); #1;
        exp_srok(1, "R9 pin fall aborted armed write");
        exp_st(8'h82, "R9 settings kept after abort");

        // R8: lock 0, pin low has no effect
        sr_write(8'h00, 8'h00, "R10 clear lock");
        set_wp(1'b0);
        pulse_en();
        exp_srok(1, "R8 pin ignored with lock clear");
        sr_write(8'h0C, 8'h0C, "R8 write with pin low");

        // R9: pin after cycle start has no effect
        set_wp(1'b1);
        pulse_en();
        pulse_arm(8'h80);
        pulse_start();
        set_wp(1'b0);
        pulse_done();
        exp_st(8'h80, "R9 pin fall after start does not stop commit");
        set_wp(1'b1);

        // R11: soft reset keeps protection bits
        pulse_en();
        @(negedge clk); #1; rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); #1; rst_n = 1'b1;
        @(posedge clk); #1;
        exp_st(8'h80, "R11 bits survive soft reset, latch cleared");

        // R12: start without latch
        pulse_start();
        exp_st(8'h80, "R12 start with latch clear ignored");

        step();
        step();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule